// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block drives an external A/D converter through a contiguous range of analog channels. Software chooses the first and last channel, a one-shot or continuous run, and the start source: a software start bit or a rising edge on an external trigger pin. The block then requests one conversion per channel in ascending order over a start/done handshake. The converter model runs a sampling phase and then a conversion phase before it returns a 12-bit value.

Each result lands in a single shared 16-bit result register and sets a sticky completion flag for its channel. When a new result arrives while the completion flag of the previously converted channel is still set, an overwrite flag is raised. Channels enabled for DMA also raise a request line that stays high until it is acknowledged. Flags are cleared by writing 1 to their positions.

Top module: `adcseq_top`

## Requirements
- R1: After a synchronous active-low reset, busy, cnv_start, done_flags, ovf_flag, dma_req and result are all zero.
- R2: Channels are converted one at a time in ascending order from cfg_first to cfg_last; when the two are equal, exactly one channel is converted.
- R3: With cfg_cont = 0, the block stops after the last channel of the range and busy returns low.
- R4: With cfg_cont = 1, the scan restarts at cfg_first after cfg_last. Writing start_val = 0 (start_wr = 1) lets the channel in progress finish, then the scan ends with no further conversion request and busy drops. This holds in either mode.
- R5: cfg_src code 0 starts a scan on start_wr with start_val = 1. Code 3 starts a scan on a rising edge of ext_trig. The other source does nothing under either code, and codes 1 and 2 start nothing.
- R6: busy is high from the clock edge that accepts a start until the last conversion completes. While busy, cur_chan gives the channel being sampled or converted.
- R7: On cnv_done, result takes the 12-bit cnv_data right-aligned, with bits 15:12 zero.
- R8: A completed channel i sets done_flags[i]. The flag stays set until a write with clr_wr = 1 and clr_done[i] = 1. Other bits are unaffected.
- R9: ovf_flag is set when a result arrives while the completion flag of the previously converted channel is still set. It is cleared only by clr_wr with clr_ovf = 1.
- R10: A start (software or trigger edge) that arrives while busy is ignored and adds no conversion.
- R11: If dma_en[i] = 1, completing channel i raises dma_req[i]. The request stays high until dma_ack[i] = 1 and does not clear the completion flag.
- R12: Each conversion request is a one-cycle cnv_start pulse with the channel on cnv_chan. The block waits for cnv_done before requesting the next channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset |
| cfg_cont | input | 1 | 0 one-shot, 1 continuous |
| cfg_first | input | 3 | first channel of scan |
| cfg_last | input | 3 | last channel of scan |
| cfg_src | input | 2 | start source code (0 software, 3 pin) |
| start_wr | input | 1 | write strobe for the start bit |
| start_val | input | 1 | value written to the start bit |
| ext_trig | input | 1 | external trigger pin, rising edge active |
| clr_wr | input | 1 | write strobe for flag clearing |
| clr_done | input | 8 | write-1-to-clear mask for completion flags |
| clr_ovf | input | 1 | write 1 to clear the overwrite flag |
| dma_en | input | 8 | per-channel DMA enable |
| dma_ack | input | 8 | per-channel DMA acknowledge |
| cnv_done | input | 1 | converter result valid pulse |
| cnv_data | input | 12 | converter result |
| busy | output | 1 | scan in progress |
| cur_chan | output | 3 | channel being handled |
| cnv_start | output | 1 | conversion request pulse |
| cnv_chan | output | 3 | channel for the request |
| result | output | 16 | shared result register |
| done_flags | output | 8 | per-channel completion flags |
| ovf_flag | output | 1 | overwrite flag |
| dma_req | output | 8 | per-channel DMA request |

## Verification
The assertions assume that cnv_done pulses for a single cycle and only after a cnv_start. They also assume that cfg_first, cfg_last and cfg_cont stay constant while busy is high, and that the channel-range check only matters when cfg_first is not above cfg_last. The bench converter model answers each request exactly once after a fixed sampling-plus-conversion latency. The bench changes the configuration only while the block is idle, and always uses ranges in ascending order.

// File: rtl/adcseq_pkg.sv
// Shared types and start-source codes for the ADC scan sequencer.
package adcseq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_e;

    localparam logic [1:0] SRC_SOFT = 2'd0;
    localparam logic [1:0] SRC_EXT  = 2'd3;
endpackage

// File: rtl/adcseq_start.sv
// Start qualifier: turns the software start bit or a rising trigger-pin edge
// into a one-cycle go pulse, chosen by the source code.
// Assumes ext_trig is already synchronous to clk. Starts seen while busy are dropped.
module adcseq_start
    import adcseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src,
    input  logic       start_wr,
    input  logic       start_val,
    input  logic       ext_trig,
    input  logic       busy,
    output logic       go,
    output logic       stop
);
    logic trig_q;
    logic trig_edge;

    // Remember last pin level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= ext_trig;
    end

    // Qualify the selected start source and decode the stop write.
    always_comb begin
        trig_edge = ext_trig & ~trig_q;
        go = 1'b0;
        if (!busy) begin
            if (src == SRC_SOFT) go = start_wr & start_val;
            else if (src == SRC_EXT) go = trig_edge;
        end
        stop = start_wr & ~start_val;
    end
endmodule

// File: rtl/adcseq_fsm.sv
// Scan state machine: walks channels first..last, issuing one converter
// request per channel and waiting for its done pulse. In continuous mode it
// wraps to the first channel until the run bit is cleared.
// Assumes configuration is stable while busy and cnv_done only follows a request.
module adcseq_fsm
    import adcseq_pkg::*;
#(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_cont,
    input  logic [CW-1:0] cfg_first,
    input  logic [CW-1:0] cfg_last,
    input  logic          go,
    input  logic          stop,
    input  logic          cnv_done,
    output logic          busy,
    output logic          cnv_start,
    output logic [CW-1:0] chan,
    output logic          done_pulse
);
    seq_state_e state;
    logic       run;
    logic       run_eff;
    logic       at_last;

    // Decode state into handshake outputs.
    always_comb begin
        busy       = (state != ST_IDLE);
        cnv_start  = (state == ST_ISSUE);
        done_pulse = (state == ST_WAIT) && cnv_done;
        run_eff    = run && !stop;
        at_last    = (chan == cfg_last);
    end

    // Advance the scan through the channel range.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            chan  <= '0;
            run   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (go) begin
                        state <= ST_ISSUE;
                        chan  <= cfg_first;
                        run   <= 1'b1;
                    end
                end
                ST_ISSUE: begin
                    state <= ST_WAIT;
                    if (stop) run <= 1'b0;
                end
                ST_WAIT: begin
                    if (stop) run <= 1'b0;
                    if (cnv_done) begin
                        if (at_last && cfg_cont && run_eff) begin
                            chan  <= cfg_first;
                            state <= ST_ISSUE;
                        end else if (at_last || !run_eff) begin
                            state <= ST_IDLE;
                            run   <= 1'b0;
                        end else begin
                            chan  <= chan + 1'b1;
                            state <= ST_ISSUE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R6: busy never drops without a conversion completing.
    a_r6_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cnv_done) |=> busy);

    // R12: each request is a single-cycle pulse.
    a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_start |=> !cnv_start);

    // R2: while busy, the channel stays inside an ascending range.
    a_r2_chan_range: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_first <= cfg_last) |-> (chan >= cfg_first && chan <= cfg_last));
endmodule

// File: rtl/adcseq_flags.sv
// Result and flag bank: captures each result, keeps sticky per-channel
// completion flags (write-1-to-clear), detects overwrites of unread data and
// holds DMA requests until acknowledged. Setting wins over clearing in one cycle.
module adcseq_flags #(
    parameter int NCH = 8,
    parameter int CW  = 3,
    parameter int DW  = 12,
    parameter int RW  = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           done_pulse,
    input  logic [CW-1:0]  done_chan,
    input  logic [DW-1:0]  cnv_data,
    input  logic           clr_wr,
    input  logic [NCH-1:0] clr_done,
    input  logic           clr_ovf,
    input  logic [NCH-1:0] dma_en,
    input  logic [NCH-1:0] dma_ack,
    output logic [RW-1:0]  result,
    output logic [NCH-1:0] done_flags,
    output logic           ovf_flag,
    output logic [NCH-1:0] dma_req
);
    localparam int PADW = RW - DW;

    logic [NCH-1:0] set_vec;
    logic [NCH-1:0] clr_vec;
    logic [CW-1:0]  prev_chan;
    logic           prev_vld;
    logic           overwrite;

    // Build per-channel set and clear vectors.
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            set_vec[i] = done_pulse && (done_chan == CW'(i));
        end
        clr_vec   = clr_wr ? clr_done : '0;
        overwrite = done_pulse && prev_vld && done_flags[prev_chan];
    end

    // Capture results and update flags and requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result     <= '0;
            done_flags <= '0;
            ovf_flag   <= 1'b0;
            dma_req    <= '0;
            prev_chan  <= '0;
            prev_vld   <= 1'b0;
        end else begin
            done_flags <= (done_flags & ~clr_vec) | set_vec;
            dma_req    <= (dma_req & ~dma_ack) | (set_vec & dma_en);
            if (overwrite)              ovf_flag <= 1'b1;
            else if (clr_wr && clr_ovf) ovf_flag <= 1'b0;
            if (done_pulse) begin
                result    <= {{PADW{1'b0}}, cnv_data};
                prev_chan <= done_chan;
                prev_vld  <= 1'b1;
            end
        end
    end

    // R7: the result follows the converter data, zero-extended.
    a_r7_result_capture: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> (result == {{PADW{1'b0}}, $past(cnv_data)}));

    // R8: a flag not being cleared stays set.
    a_r8_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (|(done_flags & ~clr_vec)) |=>
        ((done_flags & $past(done_flags & ~clr_vec)) == $past(done_flags & ~clr_vec)));

    // R11: an unacknowledged request is held.
    a_r11_dma_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (|(dma_req & ~dma_ack)) |=>
        ((dma_req & $past(dma_req & ~dma_ack)) == $past(dma_req & ~dma_ack)));

    // R9: the overwrite flag only rises after a completed conversion.
    a_r9_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(done_pulse));
endmodule

// File: rtl/adcseq_top.sv
// ADC channel scan sequencer top: joins the start qualifier, the scan state
// machine and the result/flag bank. Assumes a converter that answers every
// cnv_start with exactly one cnv_done pulse.
module adcseq_top #(
    parameter int NCH = 8,
    parameter int DW  = 12,
    parameter int RW  = 16,
    localparam int CW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_cont,
    input  logic [CW-1:0]  cfg_first,
    input  logic [CW-1:0]  cfg_last,
    input  logic [1:0]     cfg_src,
    input  logic           start_wr,
    input  logic           start_val,
    input  logic           ext_trig,
    input  logic           clr_wr,
    input  logic [NCH-1:0] clr_done,
    input  logic           clr_ovf,
    input  logic [NCH-1:0] dma_en,
    input  logic [NCH-1:0] dma_ack,
    input  logic           cnv_done,
    input  logic [DW-1:0]  cnv_data,
    output logic           busy,
    output logic [CW-1:0]  cur_chan,
    output logic           cnv_start,
    output logic [CW-1:0]  cnv_chan,
    output logic [RW-1:0]  result,
    output logic [NCH-1:0] done_flags,
    output logic           ovf_flag,
    output logic [NCH-1:0] dma_req
);
    logic          go;
    logic          stop;
    logic          done_pulse;
    logic [CW-1:0] chan;

    adcseq_start u_start (
        .clk       (clk),
        .rst_n     (rst_n),
        .src       (cfg_src),
        .start_wr  (start_wr),
        .start_val (start_val),
        .ext_trig  (ext_trig),
        .busy      (busy),
        .go        (go),
        .stop      (stop)
    );

    adcseq_fsm #(.CW(CW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_cont   (cfg_cont),
        .cfg_first  (cfg_first),
        .cfg_last   (cfg_last),
        .go         (go),
        .stop       (stop),
        .cnv_done   (cnv_done),
        .busy       (busy),
        .cnv_start  (cnv_start),
        .chan       (chan),
        .done_pulse (done_pulse)
    );

    adcseq_flags #(.NCH(NCH), .CW(CW), .DW(DW), .RW(RW)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_pulse (done_pulse),
        .done_chan  (chan),
        .cnv_data   (cnv_data),
        .clr_wr     (clr_wr),
        .clr_done   (clr_done),
        .clr_ovf    (clr_ovf),
        .dma_en     (dma_en),
        .dma_ack    (dma_ack),
        .result     (result),
        .done_flags (done_flags),
        .ovf_flag   (ovf_flag),
        .dma_req    (dma_req)
    );

    // Channel index drives both the status field and the converter select.
    always_comb begin
        cur_chan = chan;
        cnv_chan = chan;
    end
endmodule

// File: tb/tb_adcseq_top.sv
`timescale 1ns/1ps
module tb_adcseq_top;
    localparam int LAT = 8;   // sampling + conversion cycles of the model

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_cont;
    logic [2:0]  cfg_first, cfg_last;
    logic [1:0]  cfg_src;
    logic        start_wr, start_val, ext_trig;
    logic        clr_wr, clr_ovf;
    logic [7:0]  clr_done, dma_en, dma_ack;
    logic        cnv_done;
    logic [11:0] cnv_data;
    logic        busy, cnv_start, ovf_flag;
    logic [2:0]  cur_chan, cnv_chan;
    logic [15:0] result;
    logic [7:0]  done_flags, dma_req;

    int total = 0;
    int bad   = 0;
    logic [3:0] tag = 4'h0;

    always #2 clk = ~clk;

    adcseq_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_cont(cfg_cont), .cfg_first(cfg_first),
        .cfg_last(cfg_last), .cfg_src(cfg_src), .start_wr(start_wr),
        .start_val(start_val), .ext_trig(ext_trig), .clr_wr(clr_wr),
        .clr_done(clr_done), .clr_ovf(clr_ovf), .dma_en(dma_en),
        .dma_ack(dma_ack), .cnv_done(cnv_done), .cnv_data(cnv_data),
        .busy(busy), .cur_chan(cur_chan), .cnv_start(cnv_start),
        .cnv_chan(cnv_chan), .result(result), .done_flags(done_flags),
        .ovf_flag(ovf_flag), .dma_req(dma_req)
    );

    function automatic logic [11:0] fdat(input logic [2:0] ch, input logic [3:0] tg);
        return {4'hA, 1'b0, ch, tg};
    endfunction

    // Converter model: fixed latency, logs every requested channel.
    logic [2:0] lg [128];
    int         n_iss;
    int         cnt;
    logic [2:0] ch_l;
    always @(posedge clk) begin
        if (!rst_n) begin
            cnv_done <= 1'b0; cnv_data <= '0; n_iss <= 0; cnt <= 0; ch_l <= '0;
        end else begin
            cnv_done <= 1'b0;
            if (cnv_start) begin
                lg[n_iss % 128] <= cnv_chan;
                n_iss <= n_iss + 1;
                cnt   <= LAT;
                ch_l  <= cnv_chan;
            end else if (cnt != 0) begin
                cnt <= cnt - 1;
                if (cnt == 1) begin
                    cnv_done <= 1'b1;
                    cnv_data <= fdat(ch_l, tag);
                end
            end
        end
    end

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", what, got, exp);
        end
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 1000) begin @(negedge clk); n++; end
    endtask

    task automatic soft_write(input logic v);
        @(negedge clk); start_wr = 1'b1; start_val = v;
        @(negedge clk); start_wr = 1'b0; start_val = 1'b0;
    endtask

    task automatic pin_pulse();
        @(negedge clk); ext_trig = 1'b1;
        @(negedge clk); ext_trig = 1'b0;
    endtask

    task automatic clear_all();
        @(negedge clk); clr_wr = 1'b1; clr_done = 8'hFF; clr_ovf = 1'b1;
        @(negedge clk); clr_wr = 1'b0; clr_done = 8'h00; clr_ovf = 1'b0;
    endtask

    // Vector table: {pin source, first, last}.
    localparam logic [6:0] VEC [6] = '{
        {1'b0, 3'd0, 3'd0}, {1'b1, 3'd2, 3'd4}, {1'b0, 3'd3, 3'd4},
        {1'b0, 3'd0, 3'd7}, {1'b1, 3'd5, 3'd5}, {1'b1, 3'd6, 3'd7}
    };

    initial begin
        #(4 * 150000);
        bad++;
        $display("FAIL watchdog expired, run did not complete");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_cont = 1'b0; cfg_first = '0; cfg_last = '0; cfg_src = 2'd0;
        start_wr = 1'b0; start_val = 1'b0; ext_trig = 1'b0;
        clr_wr = 1'b0; clr_done = '0; clr_ovf = 1'b0; dma_en = '0; dma_ack = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 busy", busy, 0);
        chk("R1 cnv_start", cnv_start, 0);
        chk("R1 flags", done_flags, 0);
        chk("R1 ovf", ovf_flag, 0);
        chk("R1 dma", dma_req, 0);
        chk("R1 result", result, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table-driven one-shot scans
        for (int v = 0; v < 6; v++) begin
            logic       use_pin = VEC[v][6];
            logic [2:0] f = VEC[v][5:3];
            logic [2:0] l = VEC[v][2:0];
            int         nch = int'(l) - int'(f) + 1;
            int         base;
            logic [7:0] mask = '0;
            for (int c = 0; c < 8; c++) if (c >= f && c <= l) mask[c] = 1'b1;
            clear_all();
            tag = 4'(v + 1);
            cfg_first = f; cfg_last = l; cfg_cont = 1'b0;
            cfg_src = use_pin ? 2'd3 : 2'd0;
            base = n_iss;
            if (use_pin) pin_pulse(); else soft_write(1'b1);
            // R6: busy and channel index right after the start edge
            chk("R6 busy after start", busy, 1);
            chk("R6 cur_chan first", cur_chan, f);
            wait_idle();
            chk("R3 idle after one-shot", busy, 0);
            chk("R12 request count", n_iss - base, nch);
            for (int k = 0; k < nch; k++)
                chk("R2 ascending order", lg[(base + k) % 128], f + 3'(k));
            chk("R8 completion flags", done_flags, mask);
            chk("R7 result", result, {4'h0, fdat(l, tag)});
            chk("R9 overwrite in scan", ovf_flag, (nch > 1) ? 1 : 0);
        end

        // R10: trigger while busy ignored
        begin
            int base;
            clear_all();
            cfg_src = 2'd3; cfg_first = 3'd0; cfg_last = 3'd3; cfg_cont = 1'b0;
            base = n_iss;
            pin_pulse();
            repeat (5) @(negedge clk);
            pin_pulse();
            wait_idle();
            repeat (5) @(negedge clk);
            chk("R10 requests with busy trigger", n_iss - base, 4);
            chk("R10 stays idle", busy, 0);
        end

        // R5: wrong source and reserved codes start nothing
        cfg_src = 2'd0; pin_pulse(); repeat (3) @(negedge clk);
        chk("R5 pin ignored under code 0", busy, 0);
        cfg_src = 2'd3; soft_write(1'b1); repeat (3) @(negedge clk);
        chk("R5 soft ignored under code 3", busy, 0);
        cfg_src = 2'd1; soft_write(1'b1); pin_pulse(); repeat (3) @(negedge clk);
        chk("R5 code 1 starts nothing", busy, 0);

        // R4: continuous scan wraps and stops after current channel
        begin
            int base, stop_cnt;
            clear_all();
            cfg_src = 2'd0; cfg_first = 3'd1; cfg_last = 3'd2; cfg_cont = 1'b1;
            base = n_iss;
            soft_write(1'b1);
            while (n_iss < base + 5) @(negedge clk);
            soft_write(1'b0);
            stop_cnt = n_iss;
            wait_idle();
            repeat (LAT + 4) @(negedge clk);
            chk("R4 busy dropped", busy, 0);
            chk("R4 no request after stop", n_iss, stop_cnt);
            for (int k = 0; k < stop_cnt - base; k++)
                chk("R4 wrap order", lg[(base + k) % 128], (k % 2 == 0) ? 1 : 2);
            chk("R9 overwrite set", ovf_flag, 1);
            chk("R8 flags continuous", done_flags, 8'h06);
        end

        // R8/R9: write-1-to-clear of individual bits
        @(negedge clk); clr_wr = 1'b1; clr_done = 8'h02;
        @(negedge clk); clr_wr = 1'b0; clr_done = 8'h00;
        chk("R8 clear one flag", done_flags, 8'h04);
        chk("R9 ovf kept by flag clear", ovf_flag, 1);
        @(negedge clk); clr_wr = 1'b1; clr_ovf = 1'b1;
        @(negedge clk); clr_wr = 1'b0; clr_ovf = 1'b0;
        chk("R9 ovf cleared", ovf_flag, 0);
        chk("R8 flag kept by ovf clear", done_flags, 8'h04);

        // R11: DMA request held until acknowledged
        clear_all();
        cfg_cont = 1'b0; cfg_first = 3'd4; cfg_last = 3'd5; dma_en = 8'h20;
        soft_write(1'b1);
        wait_idle();
        chk("R11 request on enabled channel only", dma_req, 8'h20);
        repeat (3) @(negedge clk);
        chk("R11 request held", dma_req, 8'h20);
        @(negedge clk); dma_ack = 8'h10;
        @(negedge clk); dma_ack = 8'h00;
        chk("R11 other ack no effect", dma_req, 8'h20);
        @(negedge clk); dma_ack = 8'h20;
        @(negedge clk); dma_ack = 8'h00;
        chk("R11 cleared by ack", dma_req, 8'h00);
        chk("R11 flags untouched by ack", done_flags, 8'h30);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule